// File: doc/BRIEF.md
# Banked File Register Address Generator

This block produces the 12-bit data-memory address, the read and write strobes and the write data for every register-file access of a small 8-bit microcontroller core. A direct operand is an 8-bit f field plus an access bit. With the access bit clear, the f field is sign-extended from bit 7, and the bank register plays no part. The lower half of f then lands in low global RAM and the upper half in the top special-function page. With the access bit set, the 4-bit bank register is placed above f.

Three 12-bit pointers give indirect access. Each pointer has one indirect window address. A formed address that equals that window is replaced on the bus by the pointer value. Each pointer also has a low-byte and a high-byte address. A write to either address updates that half of the pointer. A separate port loads a whole 12-bit literal into any pointer.

A two-word move copies one byte between two 12-bit addresses. The block takes the source in the first word and the destination in the second. It then runs one read cycle and one write cycle on the memory bus.

Top module: `fsr_addr_gen`

## Requirements
- R1: After reset all three pointers are 0x000, no strobe is active while no access is requested, and the move sequencer is idle (mv_busy_o low).
- R2: With a_i = 0, f values 0x00–0x7F drive address 0x000–0x07F and f values 0x80–0xFF drive 0xF80–0xFFF, whatever bsr_i holds, in the same cycle.
- R3: With a_i = 1, the address is {bsr_i, f_i} in the same cycle.
- R4: When the formed address equals the indirect window of pointer n (0xFE0 + 4n), mem_addr_o carries pointer n in the same cycle.
- R5: A literal load (ld_valid_i, ld_sel_i = n, n in 0..2) writes ld_lit_i into pointer n at the next clock edge.
- R6: A bus write to address 0xFE1 + 4n replaces bits 7:0 of pointer n with the write data. A bus write to 0xFE2 + 4n replaces bits 11:8 with write-data bits 3:0. Either change takes effect at the next edge.
- R7: A literal load and a byte write to the same pointer in one cycle leave the literal in the pointer.
- R8: mv_first_i captures the source and a later mv_second_i captures the destination. The cycle after mv_second_i is a read of the source with mv_busy_o high. The cycle after that is a write of the destination. Its data is the mem_rdata_i value sampled in the read cycle.
- R9: While mv_busy_o is high, acc_valid_i and its fields have no effect on the bus. Exactly one strobe is active.
- R10: Outside a move, mem_rd_o equals acc_valid_i & ~acc_we_i, and mem_wr_o equals acc_valid_i & acc_we_i. mem_wdata_o is wdata_i. The two strobes are never both high.
- R11: A move source or destination equal to an indirect window is resolved through that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Direct or indirect access this cycle |
| acc_we_i | input | 1 | Access is a write |
| f_i | input | 8 | Operand register field |
| a_i | input | 1 | 0: access-mode mapping, 1: banked |
| bsr_i | input | 4 | Bank select value |
| wdata_i | input | 8 | Write data for an access |
| ld_valid_i | input | 1 | Literal pointer load |
| ld_sel_i | input | 2 | Pointer chosen for the load |
| ld_lit_i | input | 12 | Literal to load |
| mv_first_i | input | 1 | First move word, carries source |
| mv_second_i | input | 1 | Second move word, carries destination |
| mv_addr_i | input | 12 | Address carried by the move word |
| mem_rdata_i | input | 8 | Read data from data memory, same cycle |
| mem_addr_o | output | 12 | Data-memory address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mv_busy_o | output | 1 | Move read or write phase in progress |

## Verification
Direct, banked and indirect addresses are combinational. The bench checks them one time step after it drives inputs on the falling edge, in the same cycle. Pointer loads and byte writes are registered. Their effect is observed one edge later, through an indirect access at the pointer's window. The move read phase is checked on the falling edge after the edge that accepts the second word. The write phase, with its latched data, is checked one cycle after that. During the move, a conflicting access is driven to show that it does not reach the bus.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [1:0] {
    MV_IDLE = 2'd0,
    MV_SRC  = 2'd1,
    MV_RD   = 2'd2,
    MV_WR   = 2'd3
  } mv_state_e;
endpackage

// File: rtl/fsr_direct_map.sv
module fsr_direct_map #(
  parameter int F_W    = 8,
  parameter int BANK_W = 4,
  localparam int ADDR_W = F_W + BANK_W
) (
  input  logic [F_W-1:0]    f_i,
  input  logic              a_i,
  input  logic [BANK_W-1:0] bsr_i,
  output logic [ADDR_W-1:0] addr_o
);
  // access mode: sign-extend f so upper half hits the top page
  always_comb begin
    if (a_i) addr_o = {bsr_i, f_i};
    else     addr_o = {{BANK_W{f_i[F_W-1]}}, f_i};
  end
endmodule

// File: rtl/fsr_ptr_file.sv
module fsr_ptr_file #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 8,
  parameter int NUM_PTR = 3,
  parameter int STRIDE  = 4,
  parameter logic [ADDR_W-1:0] IND_BASE = 12'hFE0,
  parameter int SEL_W   = $clog2(NUM_PTR),
  localparam int HI_W   = ADDR_W - DATA_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            ld_valid_i,
  input  logic [SEL_W-1:0]                ld_sel_i,
  input  logic [ADDR_W-1:0]               ld_lit_i,
  input  logic                            wr_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  input  logic [DATA_W-1:0]               wr_data_i,
  output logic [NUM_PTR-1:0][ADDR_W-1:0]  ptr_o
);
  for (genvar n = 0; n < NUM_PTR; n++) begin : g_ptr
    localparam logic [ADDR_W-1:0] LO_A = IND_BASE + ADDR_W'(STRIDE * n + 1);
    localparam logic [ADDR_W-1:0] HI_A = IND_BASE + ADDR_W'(STRIDE * n + 2);
    logic ld_hit, lo_hit, hi_hit;
    assign ld_hit = ld_valid_i && (ld_sel_i == SEL_W'(n));
    assign lo_hit = wr_i && (wr_addr_i == LO_A);
    assign hi_hit = wr_i && (wr_addr_i == HI_A);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ptr_o[n] <= '0;
      else if (ld_hit) ptr_o[n] <= ld_lit_i;   // literal wins over byte write
      else if (lo_hit) ptr_o[n][DATA_W-1:0] <= wr_data_i;
      else if (hi_hit) ptr_o[n][ADDR_W-1:DATA_W] <= wr_data_i[HI_W-1:0];
    end
  end
endmodule

// File: rtl/fsr_indirect_resolve.sv
module fsr_indirect_resolve #(
  parameter int ADDR_W  = 12,
  parameter int NUM_PTR = 3,
  parameter int STRIDE  = 4,
  parameter logic [ADDR_W-1:0] IND_BASE = 12'hFE0
) (
  input  logic [ADDR_W-1:0]              la_i,
  input  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_i,
  output logic [ADDR_W-1:0]              pa_o
);
  always_comb begin
    pa_o = la_i;
    for (int n = 0; n < NUM_PTR; n++) begin
      if (la_i == IND_BASE + ADDR_W'(STRIDE * n)) pa_o = ptr_i[n];
    end
  end
endmodule

// File: rtl/fsr_move_seq.sv
module fsr_move_seq
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              first_i,
  input  logic              second_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              busy_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  mv_state_e         st_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [DATA_W-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= MV_IDLE;
      src_q <= '0;
      dst_q <= '0;
      dat_q <= '0;
    end else begin
      unique case (st_q)
        MV_IDLE: if (first_i) begin
          src_q <= addr_i;
          st_q  <= MV_SRC;
        end
        MV_SRC: if (second_i) begin
          dst_q <= addr_i;
          st_q  <= MV_RD;
        end
        MV_RD: begin
          dat_q <= rdata_i;
          st_q  <= MV_WR;
        end
        MV_WR: st_q <= MV_IDLE;
        default: st_q <= MV_IDLE;
      endcase
    end
  end

  assign rd_o    = (st_q == MV_RD);
  assign wr_o    = (st_q == MV_WR);
  assign busy_o  = rd_o || wr_o;
  assign addr_o  = wr_o ? dst_q : src_q;
  assign wdata_o = dat_q;
endmodule

// File: rtl/fsr_addr_gen.sv
module fsr_addr_gen #(
  parameter int F_W     = 8,
  parameter int BANK_W  = 4,
  parameter int NUM_PTR = 3,
  parameter int STRIDE  = 4,
  parameter int SEL_W   = $clog2(NUM_PTR),
  parameter logic [F_W+BANK_W-1:0] IND_BASE = 12'hFE0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    acc_valid_i,
  input  logic                    acc_we_i,
  input  logic [F_W-1:0]          f_i,
  input  logic                    a_i,
  input  logic [BANK_W-1:0]       bsr_i,
  input  logic [F_W-1:0]          wdata_i,
  input  logic                    ld_valid_i,
  input  logic [SEL_W-1:0]        ld_sel_i,
  input  logic [F_W+BANK_W-1:0]   ld_lit_i,
  input  logic                    mv_first_i,
  input  logic                    mv_second_i,
  input  logic [F_W+BANK_W-1:0]   mv_addr_i,
  input  logic [F_W-1:0]          mem_rdata_i,
  output logic [F_W+BANK_W-1:0]   mem_addr_o,
  output logic                    mem_rd_o,
  output logic                    mem_wr_o,
  output logic [F_W-1:0]          mem_wdata_o,
  output logic                    mv_busy_o
);
  localparam int ADDR_W = F_W + BANK_W;
  localparam int DATA_W = F_W;

  logic [ADDR_W-1:0]              dir_addr, mv_addr, log_addr;
  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_q;
  logic                           mv_rd, mv_wr;
  logic [DATA_W-1:0]              mv_wdata;

  fsr_direct_map #(.F_W(F_W), .BANK_W(BANK_W)) u_dir (
    .f_i    (f_i),
    .a_i    (a_i),
    .bsr_i  (bsr_i),
    .addr_o (dir_addr)
  );

  fsr_move_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .first_i  (mv_first_i),
    .second_i (mv_second_i),
    .addr_i   (mv_addr_i),
    .rdata_i  (mem_rdata_i),
    .busy_o   (mv_busy_o),
    .rd_o     (mv_rd),
    .wr_o     (mv_wr),
    .addr_o   (mv_addr),
    .wdata_o  (mv_wdata)
  );

  // move owns the bus while busy
  assign log_addr    = mv_busy_o ? mv_addr  : dir_addr;
  assign mem_rd_o    = mv_busy_o ? mv_rd    : (acc_valid_i && !acc_we_i);
  assign mem_wr_o    = mv_busy_o ? mv_wr    : (acc_valid_i && acc_we_i);
  assign mem_wdata_o = mv_busy_o ? mv_wdata : wdata_i;

  fsr_indirect_resolve #(
    .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .STRIDE(STRIDE), .IND_BASE(IND_BASE)
  ) u_res (
    .la_i  (log_addr),
    .ptr_i (ptr_q),
    .pa_o  (mem_addr_o)
  );

  // pointer halves snoop the physical write bus
  fsr_ptr_file #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PTR(NUM_PTR),
    .STRIDE(STRIDE), .IND_BASE(IND_BASE), .SEL_W(SEL_W)
  ) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_valid_i (ld_valid_i),
    .ld_sel_i   (ld_sel_i),
    .ld_lit_i   (ld_lit_i),
    .wr_i       (mem_wr_o),
    .wr_addr_i  (mem_addr_o),
    .wr_data_i  (mem_wdata_o),
    .ptr_o      (ptr_q)
  );
endmodule

// File: rtl/fsr_addr_gen_chk.sv
module fsr_addr_gen_chk #(
  parameter int F_W    = 8,
  parameter int BANK_W = 4,
  parameter int SEL_W  = 2,
  parameter logic [F_W+BANK_W-1:0] IND_BASE = 12'hFE0
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  acc_valid_i,
  input logic [F_W-1:0]        f_i,
  input logic                  a_i,
  input logic [BANK_W-1:0]     bsr_i,
  input logic                  ld_valid_i,
  input logic [SEL_W-1:0]      ld_sel_i,
  input logic [F_W+BANK_W-1:0] ld_lit_i,
  input logic [F_W-1:0]        mem_rdata_i,
  input logic [F_W+BANK_W-1:0] mem_addr_o,
  input logic                  mem_rd_o,
  input logic                  mem_wr_o,
  input logic [F_W-1:0]        mem_wdata_o,
  input logic                  mv_busy_o,
  input logic [F_W+BANK_W-1:0] ptr0_i
);
  AST_NO_DUAL_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R10

  AST_ACCESS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !mv_busy_o && !a_i && !f_i[F_W-1])
      |-> mem_addr_o == {{BANK_W{1'b0}}, f_i}); // R2

  AST_BANKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !mv_busy_o && a_i && bsr_i != '1)
      |-> mem_addr_o == {bsr_i, f_i}); // R3

  AST_IND_PTR0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !mv_busy_o && a_i && {bsr_i, f_i} == IND_BASE)
      |-> mem_addr_o == ptr0_i); // R4

  AST_LD_PTR0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && ld_sel_i == '0) |=> ptr0_i == $past(ld_lit_i)); // R5

  AST_MV_RD_THEN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mv_busy_o && mem_rd_o) |=> (mv_busy_o && mem_wr_o)); // R8

  AST_MV_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mv_busy_o && mem_wr_o && $past(mv_busy_o))
      |-> mem_wdata_o == $past(mem_rdata_i)); // R8

  AST_MV_OWNS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv_busy_o |-> (mem_rd_o ^ mem_wr_o)); // R9
endmodule

bind fsr_addr_gen fsr_addr_gen_chk #(
  .F_W(F_W), .BANK_W(BANK_W), .SEL_W(SEL_W), .IND_BASE(IND_BASE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .f_i         (f_i),
  .a_i         (a_i),
  .bsr_i       (bsr_i),
  .ld_valid_i  (ld_valid_i),
  .ld_sel_i    (ld_sel_i),
  .ld_lit_i    (ld_lit_i),
  .mem_rdata_i (mem_rdata_i),
  .mem_addr_o  (mem_addr_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .mem_wdata_o (mem_wdata_o),
  .mv_busy_o   (mv_busy_o),
  .ptr0_i      (ptr_q[0])
);

// File: tb/tb_fsr_addr_gen.sv
module tb_fsr_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid, acc_we, a, ld_valid, mv_first, mv_second;
  logic [7:0]  f, wdata, mem_rdata;
  logic [3:0]  bsr;
  logic [1:0]  ld_sel;
  logic [11:0] ld_lit, mv_addr;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr, mv_busy;
  logic [7:0]  mem_wdata;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  fsr_addr_gen dut (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_we_i(acc_we), .f_i(f), .a_i(a), .bsr_i(bsr),
    .wdata_i(wdata), .ld_valid_i(ld_valid), .ld_sel_i(ld_sel), .ld_lit_i(ld_lit),
    .mv_first_i(mv_first), .mv_second_i(mv_second), .mv_addr_i(mv_addr),
    .mem_rdata_i(mem_rdata), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
    .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata), .mv_busy_o(mv_busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_dir(input logic [7:0] ff, input logic aa, input logic [3:0] bb);
    if (aa) return {bb, ff};
    return ff >= 8'h80 ? (12'hF00 | {4'h0, ff}) : {4'h0, ff};
  endfunction

  task automatic idle();
    acc_valid = 0; acc_we = 0; a = 0; f = 0; bsr = 0; wdata = 0;
    ld_valid = 0; ld_sel = 0; ld_lit = 0;
    mv_first = 0; mv_second = 0; mv_addr = 0; mem_rdata = 0;
  endtask

  task automatic access(input logic we, input logic aa, input logic [3:0] bb,
                        input logic [7:0] ff, input logic [7:0] dd);
    acc_valid = 1; acc_we = we; a = aa; bsr = bb; f = ff; wdata = dd;
  endtask

  // read pointer n through its window (a=0, f=E0+4n)
  task automatic peek_ptr(input int n, input logic [11:0] exp, input string req);
    @(negedge clk); idle();
    access(0, 0, 4'h3, 8'hE0 + 8'(4 * n), 0);
    #1 chk(req, mem_addr, exp);
  endtask

  task automatic load(input int n, input logic [11:0] v);
    @(negedge clk); idle();
    ld_valid = 1; ld_sel = 2'(n); ld_lit = v;
  endtask

  task automatic t_reset();
    #1 chk("R1 busy", mv_busy, 0);
    chk("R1 rd", mem_rd, 0);
    chk("R1 wr", mem_wr, 0);
    for (int n = 0; n < 3; n++) peek_ptr(n, 12'h000, "R1 ptr");
  endtask

  task automatic t_access_mode();
    logic [7:0] fv [4] = '{8'h00, 8'h7F, 8'h80, 8'hC3};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); idle();
      access(0, 0, 4'(5 + i), fv[i], 0);
      #1 chk("R2 addr", mem_addr, exp_dir(fv[i], 0, 0));
    end
  endtask

  task automatic t_banked();
    @(negedge clk); idle(); access(0, 1, 4'h2, 8'h9A, 0);
    #1 chk("R3 addr", mem_addr, 12'h29A);
    @(negedge clk); idle(); access(0, 1, 4'hE, 8'h05, 0);
    #1 chk("R3 addr", mem_addr, 12'hE05);
  endtask

  task automatic t_strobes();
    @(negedge clk); idle();
    #1 chk("R10 idle rd", mem_rd, 0);
    chk("R10 idle wr", mem_wr, 0);
    @(negedge clk); idle(); access(1, 1, 4'h1, 8'h10, 8'h3C);
    #1 chk("R10 wr", {mem_rd, mem_wr}, 2'b01);
    chk("R10 wdata", mem_wdata, 8'h3C);
    @(negedge clk); idle(); access(0, 1, 4'h1, 8'h10, 8'h00);
    #1 chk("R10 rd", {mem_rd, mem_wr}, 2'b10);
  endtask

  task automatic t_load_indirect();
    load(0, 12'h3A5); load(1, 12'h123); load(2, 12'h0FF);
    peek_ptr(0, 12'h3A5, "R5 ptr0");
    peek_ptr(1, 12'h123, "R5 ptr1");
    peek_ptr(2, 12'h0FF, "R4 ptr2");
    @(negedge clk); idle(); access(0, 1, 4'hF, 8'hE4, 0); // banked reach to window 1
    #1 chk("R4 banked window", mem_addr, 12'h123);
  endtask

  task automatic t_byte_write();
    @(negedge clk); idle(); access(1, 0, 4'h0, 8'hE5, 8'hAB);  // ptr1 low
    peek_ptr(1, 12'h1AB, "R6 low");
    @(negedge clk); idle(); access(1, 1, 4'hF, 8'hE6, 8'hF7);  // ptr1 high
    peek_ptr(1, 12'h7AB, "R6 high");
    peek_ptr(0, 12'h3A5, "R6 other untouched");
  endtask

  task automatic t_priority();
    @(negedge clk); idle();
    ld_valid = 1; ld_sel = 2; ld_lit = 12'h456;
    access(1, 0, 4'h0, 8'hE9, 8'h00);                          // ptr2 low
    peek_ptr(2, 12'h456, "R7 literal wins");
  endtask

  task automatic t_move();
    @(negedge clk); idle(); mv_first = 1; mv_addr = 12'h234;
    #1 chk("R8 not busy after first", mv_busy, 0);
    @(negedge clk); idle(); mv_second = 1; mv_addr = 12'h567;
    #1 chk("R8 not busy after second", mv_busy, 0);
    @(negedge clk); idle();
    access(1, 1, 4'h7, 8'h77, 8'h11);                          // must be ignored
    mem_rdata = 8'h5A;
    #1 chk("R8 rd busy", mv_busy, 1);
    chk("R8 rd addr", mem_addr, 12'h234);
    chk("R9 rd strobes", {mem_rd, mem_wr}, 2'b10);
    @(negedge clk); idle();
    access(0, 1, 4'h7, 8'h77, 8'h00);
    mem_rdata = 8'hC3;
    #1 chk("R8 wr addr", mem_addr, 12'h567);
    chk("R9 wr strobes", {mem_rd, mem_wr}, 2'b01);
    chk("R8 wr data", mem_wdata, 8'h5A);
    @(negedge clk); idle();
    #1 chk("R8 done", mv_busy, 0);
  endtask

  task automatic t_move_indirect();
    load(0, 12'h300);
    @(negedge clk); idle(); mv_first = 1; mv_addr = 12'hFE0;  // window 0
    @(negedge clk); idle(); mv_second = 1; mv_addr = 12'hFE9; // ptr2 low
    @(negedge clk); idle(); mem_rdata = 8'h21;
    #1 chk("R11 src via ptr0", mem_addr, 12'h300);
    @(negedge clk); idle();
    #1 chk("R11 dst literal", mem_addr, 12'hFE9);
    peek_ptr(2, 12'h421, "R11 move wrote ptr2 low");
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_access_mode();
    t_banked();
    t_strobes();
    t_load_indirect();
    t_byte_write();
    t_priority();
    t_move();
    t_move_indirect();
    @(negedge clk); idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule